// File: doc/BRIEF.md
# Inverted 9-bit Half-Duplex Serial Port

This block is the serial front end of a small register-mapped device. A single wire carries traffic in both directions. Inbound frames carry a 9-bit word, then a parity bit, then two stop bits. Outbound replies carry only eight payload bits. All bit timing comes from the device's own system clock and a clock-enable input. Slowing or gating the clock therefore slows or halts the line rate by the same amount, and no state is lost.

On the wire, a payload byte is carried as its complement with the bit order reversed. The receiver undoes this coding. It checks the routing bit, the parity and both stop bits. It then reports a clean byte with a one-cycle strobe, or reports a malformed frame with a one-cycle error strobe. The transmitter takes a byte on a request, captures it into a private shift register, and drives the wire only for the length of its frame. A busy flag covers both directions. Command decoding and register storage belong to the neighbouring logic.

Top module: `hdx_serial_port`

## Requirements
- R1: After reset, `line_oe` is 0, `line_out` is 1, `busy` is 0, and neither `rx_valid` nor `rx_err` is asserted.
- R2: An inbound frame is a low start bit followed by nine word bits sent least significant first. Word bit 0 is the routing bit. Word bit i (for i from 1 to 8) carries the complement of payload bit 8-i.
- R3: After the word come a parity bit and two stop bits. A frame whose routing bit is 1, whose ten bits (word plus parity) hold an even number of ones, and whose two stop bits are both high produces `rx_valid` for exactly one cycle, with the payload on `rx_byte`.
- R4: A frame with odd parity, a low stop bit in either stop position, or a routing bit of 0 produces `rx_err` for one cycle and no `rx_valid`. `rx_valid` and `rx_err` are never high together.
- R5: The start bit is sampled at its half-bit point. A low pulse on the line that has ended before that point is treated as a false start: no strobe is produced and the receiver returns to idle.
- R6: An outbound frame is a low start bit, then eight bits, then one high stop bit. Frame bit k (for k from 0 to 7, counted after the start bit) is the complement of `tx_byte` bit 7-k. `line_oe` is high for exactly the ten bit periods of the frame and low at all other times. While `line_oe` is low, `line_out` is 1.
- R7: `tx_byte` is captured in the cycle a request is accepted. Changes to `tx_byte` after that cycle do not alter the frame being sent.
- R8: `busy` is high while a frame is being received or sent. A `tx_req` raised while `busy` is high is ignored and produces no frame.
- R9: While the transmitter is active, the receiver ignores `line_in` and produces no strobe.
- R10: In any cycle where `clk_en` is low, every counter and shift register holds its value, so `line_out`, `line_oe` and `busy` stay unchanged. The frame in progress then carries on intact once `clk_en` returns high.
- R11: Each bit lasts `CLKS_PER_BIT` cycles in which `clk_en` is high. Inbound bits are sampled at mid-bit, counted from the falling edge of the start bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; every bit period is derived from it |
| rst | input | 1 | Synchronous active-high reset |
| clk_en | input | 1 | Advance enable; when low, all line state is frozen |
| line_in | input | 1 | Level seen on the shared serial wire |
| line_out | output | 1 | Level driven onto the wire while sending |
| line_oe | output | 1 | High while the port drives the wire |
| tx_req | input | 1 | Request to send `tx_byte`; accepted only when idle |
| tx_byte | input | 8 | Reply byte, before wire coding |
| busy | output | 1 | Receive or transmit frame in progress |
| rx_valid | output | 1 | One-cycle strobe when a good byte arrives |
| rx_err | output | 1 | One-cycle strobe when a malformed frame arrives |
| rx_byte | output | 8 | Decoded payload of the last inbound frame |

## Verification
The bench builds the port with `CLKS_PER_BIT` set to 8 instead of the nominal 93. A full inbound frame then takes about a hundred cycles, so every error class, the false start, request collisions and the enable stalls all fit easily within the run. An even bit period keeps the mid-bit and end-of-frame points on whole cycles, so the bench can check the exact cycle in which `line_oe` falls. A second phase runs the same traffic with `clk_en` low one cycle in every three. This shows that bit length is counted in enabled cycles and not in raw clocks.

// File: rtl/hdx_pkg.sv
package hdx_pkg;

    localparam int RX_WORD_W  = 9;   // routing bit + 8 coded payload bits
    localparam int TX_FRAME_W = 10;  // start + 8 coded bits + stop

    typedef enum logic [2:0] {
        RX_IDLE,
        RX_START,
        RX_WORD,
        RX_PAR,
        RX_STOP1,
        RX_STOP2
    } rx_state_e;

    typedef struct packed {
        logic       valid;
        logic       err;
        logic [7:0] data;
    } rx_result_t;

    // Line coding: complement and reverse the bit order. Applying it twice
    // restores the original byte, so the same function decodes.
    function automatic logic [7:0] line_code(input logic [7:0] b);
        logic [7:0] r;
        for (int i = 0; i < 8; i++) begin
            r[i] = ~b[7 - i];
        end
        return r;
    endfunction

endpackage

// File: rtl/hdx_sync.sv
module hdx_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic en,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] chain;

    always_ff @(posedge clk) begin
        if (rst) begin
            chain <= '1;
        end else if (en) begin
            chain <= {chain[STAGES-2:0], d};
        end
    end

    assign q = chain[STAGES-1];
endmodule

// File: rtl/hdx_rx.sv
module hdx_rx
    import hdx_pkg::*;
#(
    parameter int CLKS_PER_BIT = 93
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       en,
    input  logic       hold,
    input  logic       rxd,
    output rx_result_t result,
    output logic       active
);
    localparam int HALF = CLKS_PER_BIT / 2;
    localparam int CW   = $clog2(CLKS_PER_BIT);
    localparam logic [CW-1:0] LAST_CNT = CW'(CLKS_PER_BIT - 1);
    localparam logic [CW-1:0] HALF_CNT = CW'(HALF - 1);

    rx_state_e            state;
    logic [CW-1:0]        cnt;
    logic [3:0]           nbit;
    logic [RX_WORD_W-1:0] word;
    logic                 par_bit;
    logic                 stop1_bit;
    logic                 frame_ok;

    assign frame_ok = ((^word ^ par_bit) == 1'b0) && stop1_bit && rxd && word[0];

    always_ff @(posedge clk) begin
        if (rst) begin
            state     <= RX_IDLE;
            cnt       <= '0;
            nbit      <= '0;
            word      <= '0;
            par_bit   <= 1'b0;
            stop1_bit <= 1'b0;
            result    <= '0;
        end else begin
            result.valid <= 1'b0;
            result.err   <= 1'b0;
            if (en) begin
                unique case (state)
                    RX_IDLE: begin
                        if (!hold && !rxd) begin
                            state <= RX_START;
                            cnt   <= '0;
                        end
                    end
                    RX_START: begin
                        if (cnt == HALF_CNT) begin
                            cnt  <= '0;
                            nbit <= '0;
                            state <= rxd ? RX_IDLE : RX_WORD;
                        end else begin
                            cnt <= cnt + 1'b1;
                        end
                    end
                    RX_WORD: begin
                        if (cnt == LAST_CNT) begin
                            cnt  <= '0;
                            word <= {rxd, word[RX_WORD_W-1:1]};
                            if (nbit == 4'(RX_WORD_W - 1)) begin
                                state <= RX_PAR;
                            end else begin
                                nbit <= nbit + 1'b1;
                            end
                        end else begin
                            cnt <= cnt + 1'b1;
                        end
                    end
                    RX_PAR: begin
                        if (cnt == LAST_CNT) begin
                            cnt     <= '0;
                            par_bit <= rxd;
                            state   <= RX_STOP1;
                        end else begin
                            cnt <= cnt + 1'b1;
                        end
                    end
                    RX_STOP1: begin
                        if (cnt == LAST_CNT) begin
                            cnt       <= '0;
                            stop1_bit <= rxd;
                            state     <= RX_STOP2;
                        end else begin
                            cnt <= cnt + 1'b1;
                        end
                    end
                    RX_STOP2: begin
                        if (cnt == LAST_CNT) begin
                            cnt          <= '0;
                            result.valid <= frame_ok;
                            result.err   <= !frame_ok;
                            result.data  <= line_code(word[RX_WORD_W-1:1]);
                            state        <= RX_IDLE;
                        end else begin
                            cnt <= cnt + 1'b1;
                        end
                    end
                    default: state <= RX_IDLE;
                endcase
            end
        end
    end

    assign active = (state != RX_IDLE);

    // R10
    rx_freeze_chk: assert property (@(posedge clk) disable iff (rst)
        !en |=> ($stable(state) && $stable(cnt) && $stable(word)));

    // R4
    rx_excl_chk: assert property (@(posedge clk) disable iff (rst)
        !(result.valid && result.err));

    // R3
    rx_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        result.valid |=> !result.valid);
endmodule

// File: rtl/hdx_tx.sv
module hdx_tx
    import hdx_pkg::*;
#(
    parameter int CLKS_PER_BIT = 93
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       en,
    input  logic       start,
    input  logic [7:0] data,
    output logic       txd,
    output logic       oe,
    output logic       active
);
    localparam int CW = $clog2(CLKS_PER_BIT);
    localparam logic [CW-1:0] LAST_CNT = CW'(CLKS_PER_BIT - 1);

    logic [TX_FRAME_W-1:0] shreg;
    logic [CW-1:0]         cnt;
    logic [3:0]            nbit;
    logic                  act;

    always_ff @(posedge clk) begin
        if (rst) begin
            shreg <= '1;
            cnt   <= '0;
            nbit  <= '0;
            act   <= 1'b0;
        end else if (en) begin
            if (!act) begin
                if (start) begin
                    shreg <= {1'b1, line_code(data), 1'b0};
                    cnt   <= '0;
                    nbit  <= '0;
                    act   <= 1'b1;
                end
            end else if (cnt == LAST_CNT) begin
                cnt   <= '0;
                shreg <= {1'b1, shreg[TX_FRAME_W-1:1]};
                if (nbit == 4'(TX_FRAME_W - 1)) begin
                    act <= 1'b0;
                end else begin
                    nbit <= nbit + 1'b1;
                end
            end else begin
                cnt <= cnt + 1'b1;
            end
        end
    end

    assign txd    = act ? shreg[0] : 1'b1;
    assign oe     = act;
    assign active = act;

    // R6
    tx_start_low_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(oe) |-> !txd);

    // R6
    tx_stop_high_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(oe) |-> $past(txd));

    // R10
    tx_freeze_chk: assert property (@(posedge clk) disable iff (rst)
        !en |=> ($stable(shreg) && $stable(cnt) && $stable(act)));
endmodule

// File: rtl/hdx_serial_port.sv
module hdx_serial_port
    import hdx_pkg::*;
#(
    parameter int CLKS_PER_BIT = 93,
    parameter int SYNC_STAGES  = 2
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       clk_en,
    input  logic       line_in,
    output logic       line_out,
    output logic       line_oe,
    input  logic       tx_req,
    input  logic [7:0] tx_byte,
    output logic       busy,
    output logic       rx_valid,
    output logic       rx_err,
    output logic [7:0] rx_byte
);
    logic       rxd_s;
    logic       rx_active;
    logic       tx_active;
    logic       tx_go;
    rx_result_t rx_res;

    assign busy  = rx_active | tx_active;
    assign tx_go = tx_req & !busy;

    hdx_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk (clk),
        .rst (rst),
        .en  (clk_en),
        .d   (line_in),
        .q   (rxd_s)
    );

    hdx_rx #(.CLKS_PER_BIT(CLKS_PER_BIT)) u_rx (
        .clk    (clk),
        .rst    (rst),
        .en     (clk_en),
        .hold   (tx_active | tx_go),
        .rxd    (rxd_s),
        .result (rx_res),
        .active (rx_active)
    );

    hdx_tx #(.CLKS_PER_BIT(CLKS_PER_BIT)) u_tx (
        .clk    (clk),
        .rst    (rst),
        .en     (clk_en),
        .start  (tx_go),
        .data   (tx_byte),
        .txd    (line_out),
        .oe     (line_oe),
        .active (tx_active)
    );

    assign rx_valid = rx_res.valid;
    assign rx_err   = rx_res.err;
    assign rx_byte  = rx_res.data;

    // R9
    rx_quiet_in_tx_chk: assert property (@(posedge clk) disable iff (rst)
        tx_active |-> !rx_active);

    // R8
    no_tx_while_rx_chk: assert property (@(posedge clk) disable iff (rst)
        (rx_active && !tx_active) |=> !$rose(line_oe));
endmodule

// File: tb/tb_hdx_serial_port.sv
`timescale 1ns/1ps
module tb_hdx_serial_port;
    localparam int CPB  = 8;
    localparam int HALF = CPB / 2;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       clk_en = 1'b1;
    logic       line_in = 1'b1;
    logic       line_out, line_oe, busy, rx_valid, rx_err;
    logic       tx_req = 1'b0;
    logic [7:0] tx_byte = 8'h00;
    logic [7:0] rx_byte;

    int errors = 0;
    int checks = 0;
    int en_mode = 0;     // 0: always on, 1: one cycle in three off, 2: off
    int stall_cnt = 0;
    int rx_events = 0;
    int tx_frames = 0;
    bit finished = 0;

    logic [8:0] rx_q[$];  // {is_err, byte}
    logic [7:0] tx_q[$];

    hdx_serial_port #(.CLKS_PER_BIT(CPB)) dut (
        .clk(clk), .rst(rst), .clk_en(clk_en), .line_in(line_in),
        .line_out(line_out), .line_oe(line_oe), .tx_req(tx_req),
        .tx_byte(tx_byte), .busy(busy), .rx_valid(rx_valid),
        .rx_err(rx_err), .rx_byte(rx_byte)
    );

    always #5 clk = ~clk;

    always @(negedge clk) begin
        stall_cnt <= (stall_cnt == 2) ? 0 : stall_cnt + 1;
        clk_en <= (en_mode == 0) || (en_mode == 1 && stall_cnt != 0);
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic en_edges(input int n);
        for (int i = 0; i < n; i++) begin
            @(posedge clk);
            while (!clk_en) @(posedge clk);
        end
        #1;
    endtask

    // Wire coding from R2/R6: complement, then reverse bit order.
    function automatic logic [7:0] code8(input logic [7:0] b);
        logic [7:0] r;
        for (int i = 0; i < 8; i++) r[i] = ~b[7 - i];
        return r;
    endfunction

    function automatic logic [8:0] make_word(input logic [7:0] p, input logic route);
        return {code8(p), route};
    endfunction

    task automatic drive_frame(input logic [8:0] w, input logic par,
                               input logic s1, input logic s2);
        line_in = 1'b0;
        en_edges(CPB);
        for (int i = 0; i < 9; i++) begin
            line_in = w[i];
            en_edges(CPB);
        end
        line_in = par; en_edges(CPB);
        line_in = s1;  en_edges(CPB);
        line_in = s2;  en_edges(CPB);
        line_in = 1'b1;
        en_edges(2 * CPB);
    endtask

    // R2 R3: good frame expected to deliver the payload
    task automatic rx_good(input logic [7:0] p);
        logic [8:0] w;
        w = make_word(p, 1'b1);
        rx_q.push_back({1'b0, p});
        drive_frame(w, ^w, 1'b1, 1'b1);
    endtask

    // R4: malformed frame expected to raise the error strobe
    task automatic rx_bad(input logic [7:0] p, input logic route, input logic flip_par,
                          input logic s1, input logic s2);
        logic [8:0] w;
        w = make_word(p, route);
        rx_q.push_back({1'b1, 8'h00});
        drive_frame(w, (^w) ^ flip_par, s1, s2);
    endtask

    task automatic tx_send(input logic [7:0] b, input bit expect_accept);
        tx_byte = b;
        tx_req  = 1'b1;
        if (expect_accept) tx_q.push_back(b);
        en_edges(1);
        tx_req = 1'b0;
    endtask

    // Receive monitor / scoreboard
    always @(negedge clk) begin
        if (!rst && (rx_valid || rx_err)) begin
            logic [8:0] e;
            rx_events++;
            check(!(rx_valid && rx_err), "R4", {rx_valid, rx_err}, 2'b10);
            if (rx_q.size() == 0) begin
                check(1'b0, "R4/R5/R9 unexpected strobe", {rx_err, rx_byte}, 0);
            end else begin
                e = rx_q.pop_front();
                if (e[8]) begin
                    check(rx_err && !rx_valid, "R4", {rx_valid, rx_err}, 2'b01);
                end else begin
                    check(rx_valid && !rx_err, "R3", {rx_valid, rx_err}, 2'b10);
                    check(rx_byte == e[7:0], "R2", rx_byte, e[7:0]);
                end
            end
        end
    end

    // Transmit monitor / scoreboard
    initial begin
        forever begin
            @(negedge clk);
            if (!rst && line_oe) begin
                logic [7:0] bits, exp;
                en_edges(HALF);
                check(line_out == 1'b0, "R6 start bit", line_out, 0);
                for (int k = 0; k < 8; k++) begin
                    en_edges(CPB);
                    bits[k] = line_out;
                end
                en_edges(CPB);
                check(line_out == 1'b1 && line_oe, "R6 stop bit", {line_oe, line_out}, 2'b11);
                en_edges(HALF - 1);
                check(line_oe == 1'b1, "R11 frame length", line_oe, 1);
                en_edges(1);
                check(line_oe == 1'b0, "R11 frame end", line_oe, 0);
                tx_frames++;
                if (tx_q.size() == 0) begin
                    check(1'b0, "R8 unexpected frame", bits, 0);
                end else begin
                    exp = tx_q.pop_front();
                    check(bits == code8(exp), "R6/R7 frame bits", bits, code8(exp));
                end
            end
        end
    end

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    endtask

    initial begin
        #2_000_000;
        errors++;
        checks++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        int ev0, fr0;
        logic held;
        repeat (4) @(posedge clk);
        #1 rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        check(line_oe == 0 && line_out == 1, "R1 line", {line_oe, line_out}, 2'b01);
        check(busy == 0 && !rx_valid && !rx_err, "R1 status", {busy, rx_valid, rx_err}, 0);
        en_edges(2 * CPB);

        // R2 R3 good frames
        rx_good(8'h13);
        rx_good(8'h00);
        rx_good(8'hFF);
        rx_good(8'hA5);

        // R4 errors: parity, stop1, stop2, routing bit 0
        rx_bad(8'h3C, 1'b1, 1'b1, 1'b1, 1'b1);
        rx_bad(8'h3C, 1'b1, 1'b0, 1'b0, 1'b1);
        rx_bad(8'h3C, 1'b1, 1'b0, 1'b1, 1'b0);
        rx_bad(8'h3C, 1'b0, 1'b0, 1'b1, 1'b1);
        rx_good(8'h5A);

        // R5 false start: short low pulse
        ev0 = rx_events;
        line_in = 1'b0; en_edges(2);
        line_in = 1'b1; en_edges(3 * CPB);
        check(busy == 0, "R5 back to idle", busy, 0);
        check(rx_events == ev0, "R5 no strobe", rx_events, ev0);
        rx_good(8'h81);

        // R6 R7: transmit, change byte after acceptance
        fr0 = tx_frames;
        tx_send(8'h13, 1'b1);
        check(busy == 1 && line_oe == 1, "R8 busy on tx", {busy, line_oe}, 2'b11);
        tx_byte = 8'hEE;
        en_edges(CPB);
        // R8: request while busy is ignored
        tx_send(8'h77, 1'b0);
        // R9: line activity during tx is ignored
        ev0 = rx_events;
        line_in = 1'b0; en_edges(4 * CPB);
        line_in = 1'b1;
        wait (!line_oe);
        en_edges(2 * CPB);
        check(rx_events == ev0, "R9 rx quiet during tx", rx_events, ev0);
        check(tx_frames == fr0 + 1, "R8 one frame", tx_frames, fr0 + 1);

        // R8: request during receive is ignored
        fork
            begin
                logic [8:0] w;
                w = make_word(8'h42, 1'b1);
                rx_q.push_back({1'b0, 8'h42});
                drive_frame(w, ^w, 1'b1, 1'b1);
            end
            begin
                en_edges(3 * CPB);
                check(busy == 1, "R8 busy on rx", busy, 1);
                tx_send(8'h99, 1'b0);
            end
        join
        en_edges(2 * CPB);
        check(tx_frames == fr0 + 1, "R8 no frame during rx", tx_frames, fr0 + 1);

        // R10: freeze mid-frame
        tx_send(8'hC4, 1'b1);
        en_edges(3 * CPB + 2);
        en_mode = 2;
        @(negedge clk); @(negedge clk);
        held = line_out;
        for (int i = 0; i < 20; i++) begin
            @(negedge clk);
            check(line_out == held && line_oe && busy, "R10 frozen",
                  {line_oe, busy, line_out}, {2'b11, held});
        end
        en_mode = 0;
        wait (!line_oe);
        en_edges(2 * CPB);

        // R10 R11: periodic stalls, lengths counted in enabled cycles
        en_mode = 1;
        en_edges(3);
        rx_good(8'h6D);
        rx_bad(8'h6D, 1'b1, 1'b1, 1'b1, 1'b1);
        tx_send(8'h2B, 1'b1);
        wait (!line_oe);
        en_edges(2 * CPB);
        en_mode = 0;
        en_edges(2 * CPB);

        check(rx_q.size() == 0, "R3 all rx consumed", rx_q.size(), 0);
        check(tx_q.size() == 0, "R6 all tx consumed", tx_q.size(), 0);
        finish_run();
    end
endmodule